// File: doc/BRIEF.md
# Multiplexed-Bus Memory Responder

This block is the external agent on a shared, multiplexed processor bus. It acts as a small memory. When the processor raises its valid strobe with a request command, the responder captures the byte address and decodes the kind of request: read or write, single word or four-word block, and a byte count. A write is then served by taking data words off the bus in the slots of a selectable data/wait pattern. Words are stored in consecutive doublewords of an internal array. A sub-doubleword write touches only the byte lanes it addresses.

For a read, the responder waits until the processor has handed the bus over with its release strobe. It then drives the words back under its own valid strobe, starting a fixed latency after the request. The block response follows two data cycles, two idle cycles and two more data cycles. A command-bus qualifier marks the final word, and one cycle later the responder stops driving the bus. Two ready outputs tell the processor whether a new read or write can be taken.

Top module: `mresp_top`

## Requirements
- R1: After reset, rd_ready and wr_ready are 1, and bus_drive and agent_valid are 0.
- R2: A request is taken in a cycle with proc_valid high, bus_cmd_in[5]=1 and the block idle. The request fields are: bus_cmd_in[4] (1 = write), bus_cmd_in[3] (1 = block of 4 words) and bus_cmd_in[2:0] (byte count minus one). The byte address is on bus_data_in, and address bits [6:3] select one of 16 doublewords.
- R3: rd_ready and wr_ready are 0 from the cycle after a request is taken until the transaction completes. They return to 1 in the cycle after the last word.
- R4: The first read word has agent_valid high exactly 4 cycles after the request cycle if release was seen by the third cycle after it. Otherwise the first word comes one cycle after the cycle in which release is seen.
- R5: bus_drive stays 0 until proc_release has been seen for the current read.
- R6: A block read returns the 4 words of the 4-aligned block, in ascending order, in slots data, data, idle, idle, data, data. A single read returns one word.
- R7: Each returned word carries bus_cmd_out[0]=1 if it is the final word and 0 otherwise. agent_valid is high only in data slots, while the responder drives the bus.
- R8: In the cycle after the final read word, bus_drive is 0.
- R9: wr_pattern_sel chooses which write slots carry data, with slots counted from the cycle after the request: 0 = every slot, 1 = every other slot, 2 = two data then two idle, 3 = one data then three idle. A valid word offered in an idle slot is ignored.
- R10: A block write stores its 4 words into consecutive doublewords of the 4-aligned block, in ascending order.
- R11: A single write updates only byte lanes from address bits [2:0] through those bits plus the byte count minus one. Bytes are taken from their natural lanes on bus_data_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| proc_valid | input | 1 | Processor valid strobe for a command or data word |
| proc_release | input | 1 | Processor hands the bus to the responder |
| bus_data_in | input | 64 | Address or write data from the processor |
| bus_cmd_in | input | 6 | Command or data qualifier from the processor |
| wr_pattern_sel | input | 2 | Static write data/wait pattern code |
| bus_data_out | output | 64 | Read data driven by the responder |
| bus_cmd_out | output | 6 | Read-data qualifier; bit 0 marks the last word |
| bus_drive | output | 1 | Responder owns and drives the shared bus |
| agent_valid | output | 1 | Responder valid strobe for a data word |
| rd_ready | output | 1 | A new read request can be taken |
| wr_ready | output | 1 | A new write request can be taken |

## Verification
Block writes are tried with all four pattern codes. For codes 1, 2 and 3, junk words are offered in the idle slots, so a responder that takes words on every valid strobe is told apart from one that honours the pattern. Block reads are issued at a mid-block address with early, on-time and late release. This separates address alignment, the fixed latency and the wait for release, and each word's arrival cycle is compared against the expected data/idle slot. Sub-doubleword writes at an offset, followed by single reads, show whether the byte-lane merge keeps the neighbouring bytes.

// File: rtl/mresp_pkg.sv
package mresp_pkg;

   localparam int CMD_W   = 6;
   localparam int CB_REQ  = 5;
   localparam int CB_WR   = 4;
   localparam int CB_BLK  = 3;
   localparam int CB_LAST = 0;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_RD_WAIT,
      ST_RD_SEND,
      ST_WR
   } mresp_state_e;

   // slot pattern: 0 all data, 1 D-, 2 DD--, 3 D---
   function automatic logic pat_is_data(input logic [1:0] code, input logic [1:0] slot);
      logic r;
      case (code)
         2'd0:    r = 1'b1;
         2'd1:    r = ~slot[0];
         2'd2:    r = ~slot[1];
         default: r = (slot == 2'd0);
      endcase
      return r;
   endfunction

endpackage

// File: rtl/mresp_slot_gen.sv
module mresp_slot_gen
   import mresp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hold,
   input  logic [1:0] code,
   output logic       is_data
);

   logic [1:0] slot_q;

   always_ff @(posedge clk) begin
      if (!rst_n || hold) slot_q <= 2'd0;
      else                slot_q <= slot_q + 2'd1;
   end

   assign is_data = pat_is_data(code, slot_q);

endmodule

// File: rtl/mresp_mem.sv
module mresp_mem #(
   parameter int DATA_W = 64,
   parameter int DEPTH  = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [$clog2(DEPTH)-1:0] waddr,
   input  logic [DATA_W/8-1:0]      wmask,
   input  logic [DATA_W-1:0]        wdata,
   input  logic [$clog2(DEPTH)-1:0] raddr,
   output logic [DATA_W-1:0]        rdata
);

   localparam int BYTES = DATA_W / 8;

   initial begin
      assert (DATA_W % 8 == 0) else $error("DATA_W must be whole bytes");
      assert ((1 << $clog2(DEPTH)) == DEPTH) else $error("DEPTH must be a power of two");
   end

   for (genvar g = 0; g < BYTES; g++) begin : g_lane
      logic [7:0] lane_q [DEPTH];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) lane_q[i] <= 8'h00;
         end else if (we && wmask[g]) begin
            lane_q[waddr] <= wdata[8*g +: 8];
         end
      end

      assign rdata[8*g +: 8] = lane_q[raddr];
   end

endmodule

// File: rtl/mresp_top.sv
module mresp_top
   import mresp_pkg::*;
#(
   parameter int DATA_W           = 64,
   parameter int DEPTH            = 16,
   parameter int BLOCK_WORDS      = 4,
   parameter int READ_LAT         = 4,
   parameter int RD_PAT           = 2,
   parameter bit RD_PAT_FROM_PORT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              proc_valid,
   input  logic              proc_release,
   input  logic [DATA_W-1:0] bus_data_in,
   input  logic [CMD_W-1:0]  bus_cmd_in,
   input  logic [1:0]        wr_pattern_sel,
   output logic [DATA_W-1:0] bus_data_out,
   output logic [CMD_W-1:0]  bus_cmd_out,
   output logic              bus_drive,
   output logic              agent_valid,
   output logic              rd_ready,
   output logic              wr_ready
);

   localparam int BYTES = DATA_W / 8;
   localparam int OFF_W = $clog2(BYTES);
   localparam int IDX_W = $clog2(DEPTH);
   localparam int BLK_W = $clog2(BLOCK_WORDS);
   localparam int CNT_W = BLK_W + 1;
   localparam int LAT_W = $clog2(READ_LAT + 1);

   initial begin
      assert (OFF_W == 3) else $error("byte count field needs 8-byte words");
      assert (BLOCK_WORDS >= 2 && (1 << BLK_W) == BLOCK_WORDS) else $error("BLOCK_WORDS");
      assert (BLOCK_WORDS <= DEPTH) else $error("block larger than array");
      assert (READ_LAT >= 2) else $error("READ_LAT must be at least 2");
      assert (RD_PAT >= 0 && RD_PAT <= 3) else $error("RD_PAT out of range");
      assert (DATA_W > OFF_W + IDX_W) else $error("address does not fit");
   end

   function automatic logic [BYTES-1:0] lane_mask(input logic [OFF_W-1:0] off,
                                                  input logic [2:0] sz);
      logic [BYTES-1:0] m;
      for (int i = 0; i < BYTES; i++)
         m[i] = (i >= int'(off)) && (i <= int'(off) + int'(sz));
      return m;
   endfunction

   mresp_state_e     state_q;
   logic [IDX_W-1:0] base_q;
   logic             blk_q;
   logic [OFF_W-1:0] off_q;
   logic [2:0]       size_q;
   logic [CNT_W-1:0] cnt_q;
   logic [LAT_W-1:0] lat_q;
   logic             rel_seen_q;

   logic             accept, req_wr, req_blk, wr_take, last_word;
   logic             rd_slot, wr_slot;
   logic [1:0]       rd_code;
   logic [IDX_W-1:0] req_idx, req_base, word_idx;
   logic [DATA_W-1:0] rdata;
   logic             unused_bits;

   assign req_wr  = bus_cmd_in[CB_WR];
   assign req_blk = bus_cmd_in[CB_BLK];
   assign req_idx = bus_data_in[OFF_W +: IDX_W];
   assign req_base = req_blk ? {req_idx[IDX_W-1:BLK_W], {BLK_W{1'b0}}} : req_idx;
   assign accept  = (state_q == ST_IDLE) && proc_valid && bus_cmd_in[CB_REQ];
   assign unused_bits = ^bus_data_in[DATA_W-1:OFF_W+IDX_W];

   assign last_word = (cnt_q == (blk_q ? CNT_W'(BLOCK_WORDS - 1) : '0));
   assign word_idx  = base_q + IDX_W'(cnt_q);

   if (RD_PAT_FROM_PORT) begin : g_rdpat_port
      assign rd_code = wr_pattern_sel;
   end else begin : g_rdpat_fixed
      assign rd_code = 2'(RD_PAT);
   end

   mresp_slot_gen u_rd_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .hold   (state_q != ST_RD_SEND),
      .code   (rd_code),
      .is_data(rd_slot)
   );

   mresp_slot_gen u_wr_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .hold   (state_q != ST_WR),
      .code   (wr_pattern_sel),
      .is_data(wr_slot)
   );

   assign wr_take = (state_q == ST_WR) && wr_slot && proc_valid && !bus_cmd_in[CB_REQ];

   mresp_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (wr_take),
      .waddr(word_idx),
      .wmask(blk_q ? {BYTES{1'b1}} : lane_mask(off_q, size_q)),
      .wdata(bus_data_in),
      .raddr(word_idx),
      .rdata(rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         base_q     <= '0;
         blk_q      <= 1'b0;
         off_q      <= '0;
         size_q     <= '0;
         cnt_q      <= '0;
         lat_q      <= '0;
         rel_seen_q <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: if (accept) begin
               base_q     <= req_base;
               blk_q      <= req_blk;
               off_q      <= bus_data_in[OFF_W-1:0];
               size_q     <= bus_cmd_in[2:0];
               cnt_q      <= '0;
               lat_q      <= LAT_W'(1);
               rel_seen_q <= 1'b0;
               state_q    <= req_wr ? ST_WR : ST_RD_WAIT;
            end
            ST_RD_WAIT: begin
               rel_seen_q <= rel_seen_q | proc_release;
               if (lat_q != LAT_W'(READ_LAT - 1)) lat_q <= lat_q + LAT_W'(1);
               else if (rel_seen_q || proc_release) state_q <= ST_RD_SEND;
            end
            ST_RD_SEND: if (rd_slot) begin
               cnt_q <= cnt_q + CNT_W'(1);
               if (last_word) state_q <= ST_IDLE;
            end
            ST_WR: if (wr_take) begin
               cnt_q <= cnt_q + CNT_W'(1);
               if (last_word) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign bus_drive    = (state_q == ST_RD_SEND);
   assign agent_valid  = bus_drive && rd_slot;
   assign bus_data_out = agent_valid ? rdata : '0;
   assign bus_cmd_out  = agent_valid ? {{(CMD_W-1){1'b0}}, last_word} : '0;
   assign rd_ready     = (state_q == ST_IDLE);
   assign wr_ready     = (state_q == ST_IDLE);

   // checker-only cycle count since the read request
   logic [LAT_W-1:0] since_q;
   always_ff @(posedge clk) begin
      if (!rst_n)                        since_q <= '0;
      else if (accept && !req_wr)        since_q <= LAT_W'(1);
      else if (since_q != '0 && since_q != LAT_W'(READ_LAT)) since_q <= since_q + LAT_W'(1);
   end

   // R3
   ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (!rd_ready && !wr_ready));
   // R4
   read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_drive) |-> (since_q == LAT_W'(READ_LAT)));
   // R5
   drive_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_drive |-> rel_seen_q);
   // R7
   final_word_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_drive) |-> $past(agent_valid && bus_cmd_out[CB_LAST]));
   // R8
   bus_freed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (agent_valid && bus_cmd_out[CB_LAST]) |=> !bus_drive);

endmodule

// File: tb/tb_mresp_top.sv
module tb_mresp_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        proc_valid = 1'b0;
   logic        proc_release = 1'b0;
   logic [63:0] bus_data_in = '0;
   logic [5:0]  bus_cmd_in = '0;
   logic [1:0]  wr_pattern_sel = 2'd0;
   logic [63:0] bus_data_out;
   logic [5:0]  bus_cmd_out;
   logic        bus_drive, agent_valid, rd_ready, wr_ready;

   always #5 clk = ~clk;

   mresp_top dut (
      .clk(clk), .rst_n(rst_n), .proc_valid(proc_valid), .proc_release(proc_release),
      .bus_data_in(bus_data_in), .bus_cmd_in(bus_cmd_in), .wr_pattern_sel(wr_pattern_sel),
      .bus_data_out(bus_data_out), .bus_cmd_out(bus_cmd_out), .bus_drive(bus_drive),
      .agent_valid(agent_valid), .rd_ready(rd_ready), .wr_ready(wr_ready)
   );

   typedef struct {
      logic [63:0] d;
      logic        last;
      int          cyc;
   } exp_t;

   exp_t        q[$];
   logic [63:0] model [16];
   int          n_chk = 0;
   int          n_err = 0;
   int          cyc = 0;
   logic        prev_last = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
   endtask

   // R9 pattern as stated in the requirement
   function automatic logic slot_data(input int code, input int s);
      case (code)
         0: return 1'b1;
         1: return (s % 2) == 0;
         2: return (s % 4) < 2;
         default: return (s % 4) == 0;
      endcase
   endfunction

   // monitor: scoreboard pop and bus-release check
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_last) chk(!bus_drive, "R8 bus after last word", 64'(bus_drive), 64'd0);
         prev_last = 1'b0;
         if (agent_valid) begin
            if (q.size() == 0) begin
               chk(1'b0, "R6 unexpected read word", bus_data_out, 64'd0);
            end else begin
               exp_t e;
               e = q.pop_front();
               chk(bus_data_out == e.d, "R6/R10/R11 read data", bus_data_out, e.d);
               chk(bus_cmd_out[0] == e.last, "R7 last qualifier", 64'(bus_cmd_out), 64'(e.last));
               chk(cyc == e.cyc, "R4/R6 word cycle", 64'(cyc), 64'(e.cyc));
               prev_last = bus_cmd_out[0];
            end
         end
      end
   end

   task automatic rd(input logic [63:0] addr, input logic blk, input int rel_dly);
      int t0, first, n, base;
      @(posedge clk); #1;
      chk(rd_ready, "R3 rd_ready before read", 64'(rd_ready), 64'd1);
      proc_valid = 1'b1;
      bus_cmd_in = {1'b1, 1'b0, blk, 3'd7};
      bus_data_in = addr;
      t0 = cyc;
      first = (t0 + 4 > t0 + rel_dly + 1) ? t0 + 4 : t0 + rel_dly + 1;
      n = blk ? 4 : 1;
      base = blk ? int'(addr[6:5]) * 4 : int'(addr[6:3]);
      for (int k = 0; k < n; k++) begin
         exp_t e;
         e.d = model[base + k];
         e.last = (k == n - 1);
         e.cyc = first + (k / 2) * 4 + (k % 2);
         q.push_back(e);
      end
      for (int d = 1; d <= rel_dly; d++) begin
         @(posedge clk); #1;
         proc_valid = 1'b0;
         bus_cmd_in = '0;
         proc_release = (d == rel_dly);
         if (d == 1) chk(!rd_ready && !wr_ready, "R3 ready low during read",
                         64'({rd_ready, wr_ready}), 64'd0);
         @(negedge clk);
         chk(!bus_drive, "R5 no drive before release", 64'(bus_drive), 64'd0);
      end
      @(posedge clk); #1;
      proc_release = 1'b0;
      while (q.size() != 0) @(negedge clk);
      @(posedge clk); #1;
      @(negedge clk);
      chk(rd_ready && wr_ready, "R3 ready back after read", 64'({rd_ready, wr_ready}), 64'd3);
   endtask

   task automatic wr_blk(input logic [63:0] addr, input int code, input logic junk, input logic [63:0] seed);
      int words, s, base;
      base = int'(addr[6:5]) * 4;
      wr_pattern_sel = 2'(code);
      @(posedge clk); #1;
      chk(wr_ready, "R3 wr_ready before write", 64'(wr_ready), 64'd1);
      proc_valid = 1'b1;
      bus_cmd_in = {1'b1, 1'b1, 1'b1, 3'd7};
      bus_data_in = addr;
      words = 0;
      s = 0;
      while (words < 4) begin
         @(posedge clk); #1;
         if (s == 0) chk(!wr_ready, "R3 wr_ready low during write", 64'(wr_ready), 64'd0);
         if (slot_data(code, s)) begin
            proc_valid = 1'b1;
            bus_cmd_in = {5'd0, words == 3};
            bus_data_in = seed + 64'(words) * 64'h0101_0101_0101_0101;
            model[base + words] = bus_data_in;
            words++;
         end else if (junk) begin
            proc_valid = 1'b1;
            bus_cmd_in = 6'd0;
            bus_data_in = 64'hDEAD_BEEF_0BAD_F00D;
         end else begin
            proc_valid = 1'b0;
         end
         s++;
      end
      @(posedge clk); #1;
      proc_valid = 1'b0;
      bus_cmd_in = '0;
      @(negedge clk);
      chk(wr_ready, "R3 wr_ready back after write", 64'(wr_ready), 64'd1);
   endtask

   task automatic wr_sub(input logic [63:0] addr, input int nbytes, input logic [63:0] data);
      int idx, off;
      idx = int'(addr[6:3]);
      off = int'(addr[2:0]);
      @(posedge clk); #1;
      proc_valid = 1'b1;
      bus_cmd_in = {1'b1, 1'b1, 1'b0, 3'(nbytes - 1)};
      bus_data_in = addr;
      @(posedge clk); #1;
      bus_cmd_in = 6'd1;
      bus_data_in = data;
      for (int b = off; b < off + nbytes; b++) model[idx][8*b +: 8] = data[8*b +: 8];
      @(posedge clk); #1;
      proc_valid = 1'b0;
      bus_cmd_in = '0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      chk(1'b0, "watchdog expired", 64'(cyc), 64'd0);
      finish_run();
   end

   initial begin
      for (int i = 0; i < 16; i++) model[i] = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(rd_ready, "R1 rd_ready after reset", 64'(rd_ready), 64'd1);
      chk(wr_ready, "R1 wr_ready after reset", 64'(wr_ready), 64'd1);
      chk(!bus_drive, "R1 bus_drive after reset", 64'(bus_drive), 64'd0);
      chk(!agent_valid, "R1 agent_valid after reset", 64'(agent_valid), 64'd0);

      // R2/R10 code 0 block write, mid-block read address, early release
      wr_blk(64'h00, 0, 1'b0, 64'h1111_0000_0000_0001);
      rd(64'h10, 1'b1, 1);
      // R9 code 2 with junk in idle slots, release on the last allowed cycle
      wr_blk(64'h20, 2, 1'b1, 64'h2222_0000_0000_0002);
      rd(64'h38, 1'b1, 3);
      // R11 two-byte write at byte 3 of word 5, then single read
      wr_sub(64'h2B, 2, 64'h0000_00AB_CD00_0000);
      rd(64'h28, 1'b0, 1);
      // R9 code 1 with junk, R4/R5 late release
      wr_blk(64'h40, 1, 1'b1, 64'h3333_0000_0000_0003);
      rd(64'h48, 1'b1, 6);
      // R9 code 3 with junk
      wr_blk(64'h60, 3, 1'b1, 64'h4444_0000_0000_0004);
      rd(64'h60, 1'b1, 2);
      // R11 single byte at offset 7 and full-word single write
      wr_sub(64'h3F, 1, 64'h5A00_0000_0000_0000);
      rd(64'h38, 1'b0, 1);
      wr_sub(64'h08, 8, 64'h0123_4567_89AB_CDEF);
      rd(64'h00, 1'b1, 2);

      repeat (3) @(posedge clk);
      finish_run();
   end

endmodule